// File: doc/BRIEF.md
# Dual-Input Rising-Edge Decade Counter

This block counts rising edges from two independent button-style inputs into one shared counter that runs from 0 to 9 and then wraps. A single free-running system clock clocks every register. The button levels are treated as data. Each input passes through a two-flop synchronizer and then a rising-edge detector, which compares the current synchronized sample with the sample from the previous cycle.

The two edge pulses are summed before they reach the counter. Rising edges that appear on both inputs in the same cycle therefore advance the count by two. One synchronous, active-high reset clears the counter, the synchronizer flops and the previous-sample flops together. Debouncing and display decoding are left to logic outside the block.

Top module: `edge_decade_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count_o` becomes 0 after that edge. With both inputs low, `count_o` stays 0 after reset is released.
- R2: A 0-to-1 change on `btn_a`, applied between clock edges, raises `count_o` by one. The new value appears after the third rising clock edge that follows the change (two synchronizer stages, then the counter register). After the first two of those edges the value is unchanged.
- R3: A 0-to-1 change on `btn_b` raises `count_o` by one with the same latency as R2, whether `btn_a` is low or held high.
- R4: `count_o` is an unsigned binary number that is always between 0 and 9. A single advance from 9 gives 0.
- R5: Rising edges detected on both inputs in the same cycle advance `count_o` by two, modulo 10. From 8 the result is 0, and from 9 it is 1.
- R6: A level held high produces exactly one count, at its rising edge. A falling edge produces no count.
- R7: An input that is already high when reset is released is taken as one rising edge and gives exactly one count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock; the only clock of the block |
| rst | input | 1 | Synchronous active-high reset |
| btn_a | input | 1 | First button level, asynchronous to `clk` |
| btn_b | input | 1 | Second button level, asynchronous to `clk` |
| count_o | output | 4 | Count value 0 to 9, driven directly by the counter register |

## Verification
The counter is driven from every start value 0 to 9 with three input patterns: a lone edge on `btn_a`, a lone edge on `btn_b`, and edges on both inputs in the same cycle. The lone-edge patterns show the wrap from 9 and confirm that each input has its own path. The same-cycle pattern tells a two-count merge apart from a one-count merge (8 must give 0, not 9).

A `btn_b` edge applied while `btn_a` is held high shows that the inputs do not gate each other. Sampling after the second and the third clock edge pins down the latency. Long holds and releases confirm that only rising edges count. An input held high across reset release shows how the cleared history is treated.

// File: rtl/edc_pkg.sv
package edc_pkg;
    parameter int MODULUS    = 10;
    parameter int CNT_W      = $clog2(MODULUS);
    parameter int SYNC_DEPTH = 2;
    parameter int N_SRC      = 2;

    typedef logic [CNT_W-1:0] count_t;

    typedef struct packed {
        logic a;
        logic b;
    } hit_pair_t;

    function automatic int hits_of(input hit_pair_t h);
        return int'(h.a) + int'(h.b);
    endfunction

    function automatic count_t wrap_add(input count_t cur, input int inc);
        int s;
        s = int'(cur) + inc;
        if (s >= MODULUS) s = s - MODULUS;
        return count_t'(s);
    endfunction

    function automatic int wrap_dist(input count_t from_v, input count_t to_v);
        return (int'(to_v) + MODULUS - int'(from_v)) % MODULUS;
    endfunction
endpackage

// File: rtl/edc_sync.sv
module edc_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [DEPTH-1:0] stage_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b0;
                    else     stage_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[DEPTH-1];
endmodule

// File: rtl/edc_rise.sv
module edc_rise (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_prev_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_prev_q <= 1'b0;
        else     lvl_prev_q <= lvl;
    end

    assign rise = lvl & ~lvl_prev_q;
endmodule

// File: rtl/edc_accum.sv
module edc_accum
    import edc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  hit_pair_t hits,
    output count_t    value
);
    count_t value_q;

    always_ff @(posedge clk) begin
        if (rst) value_q <= '0;
        else     value_q <= wrap_add(value_q, hits_of(hits));
    end

    assign value = value_q;
endmodule

// File: rtl/edge_decade_counter.sv
module edge_decade_counter
    import edc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             btn_a,
    input  logic             btn_b,
    output logic [CNT_W-1:0] count_o
);
    logic [N_SRC-1:0] raw_lvl;
    logic [N_SRC-1:0] sync_lvl;
    logic [N_SRC-1:0] rise_v;
    logic             hit_a;
    logic             hit_b;
    hit_pair_t        hits;
    count_t           value;

    assign raw_lvl = {btn_b, btn_a};

    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            edc_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
                .clk(clk), .rst(rst), .d_async(raw_lvl[s]), .q_sync(sync_lvl[s])
            );
            edc_rise u_rise (
                .clk(clk), .rst(rst), .lvl(sync_lvl[s]), .rise(rise_v[s])
            );
        end
    endgenerate

    assign hit_a  = rise_v[0];
    assign hit_b  = rise_v[1];
    assign hits.a = hit_a;
    assign hits.b = hit_b;

    edc_accum u_acc (
        .clk(clk), .rst(rst), .hits(hits), .value(value)
    );

    assign count_o = value;
endmodule

// File: rtl/edc_checker.sv
module edc_checker
    import edc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count_o,
    input logic             hit_a,
    input logic             hit_b
);
    logic valid_q;

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= 1'b1;
    end

    // R1: reset clears the count on the next edge
    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> count_o == '0);

    // R4: count stays inside 0..9
    assert_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> int'(count_o) < MODULUS);

    // R5: the count moves by exactly the number of edges detected one cycle earlier
    assert_step_matches_hits_R5: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> wrap_dist($past(count_o), count_o)
                    == int'($past(hit_a)) + int'($past(hit_b)));

    // R6: an edge pulse never lasts two cycles
    assert_single_pulse_a_R6: assert property (@(posedge clk) disable iff (rst)
        hit_a |=> !hit_a);
    assert_single_pulse_b_R6: assert property (@(posedge clk) disable iff (rst)
        hit_b |=> !hit_b);
endmodule

bind edge_decade_counter edc_checker u_chk (
    .clk(clk), .rst(rst), .count_o(count_o), .hit_a(hit_a), .hit_b(hit_b)
);

// File: tb/sim_edge_decade_counter.sv
`timescale 1ns/1ps
module sim_edge_decade_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_a = 1'b0;
    logic       btn_b = 1'b0;
    logic [3:0] count_o;
    int n_cmp = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    edge_decade_counter u0 (
        .clk(clk), .rst(rst), .btn_a(btn_a), .btn_b(btn_b), .count_o(count_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int expv);
        n_cmp++;
        if (int'(count_o) != expv) begin
            n_bad++;
            $display("FAIL %s: count_o=%0d expected=%0d", tag, count_o, expv);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Raise the chosen inputs at a negedge, check the latency, hold, then release.
    task automatic press(input bit a, input bit b, input string tag);
        int inc;
        inc = int'(a) + int'(b);
        @(negedge clk);
        if (a) btn_a = 1'b1;
        if (b) btn_b = 1'b1;
        cycles(2);
        check({tag, " before third edge"}, exp_cnt);
        cycles(1);
        exp_cnt = (exp_cnt + inc) % 10;
        check(tag, exp_cnt);
        if (a) btn_a = 1'b0;
        if (b) btn_b = 1'b0;
        cycles(4);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        cycles(2);
        check("R1 during reset", 0);
        rst = 1'b0;
        exp_cnt = 0;
    endtask

    initial begin
        cycles(3);
        check("R1 reset value", 0);
        rst = 1'b0;
        cycles(5);
        check("R1 idle after release", 0);

        // R2 / R4: single edges on btn_a through two full wraps
        for (int i = 0; i < 20; i++) press(1'b1, 1'b0, "R2 R4 btn_a step");
        // R3: single edges on btn_b through one full wrap
        for (int i = 0; i < 10; i++) press(1'b0, 1'b1, "R3 btn_b step");

        // R3: btn_b edge while btn_a is held high
        @(negedge clk); btn_a = 1'b1;
        cycles(3);
        exp_cnt = (exp_cnt + 1) % 10;
        check("R3 btn_a rise", exp_cnt);
        press(1'b0, 1'b1, "R3 btn_b with btn_a high");
        // R6: the long hold of btn_a adds nothing, its release adds nothing
        cycles(20);
        check("R6 hold high", exp_cnt);
        btn_a = 1'b0;
        cycles(6);
        check("R6 falling edge", exp_cnt);

        // R5: edges on both inputs in the same cycle, from every start value
        for (int s = 0; s < 10; s++) begin
            do_reset();
            for (int k = 0; k < s; k++) press(1'b1, 1'b0, "R2 preset");
            press(1'b1, 1'b1, "R5 dual edge");
        end

        // R7: input held high through reset release counts once
        @(negedge clk);
        rst = 1'b1; btn_b = 1'b1;
        cycles(2);
        check("R1 reset with input high", 0);
        rst = 1'b0;
        cycles(8);
        check("R7 high across reset", 1);
        btn_b = 1'b0;
        cycles(4);
        check("R7 release after reset", 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule